// File: doc/BRIEF.md
# LCD Nibble Initialisation Sequencer

This block drives the 4-bit parallel bus of a character LCD while the panel powers up. Software, or a small ROM walker, feeds it 32-bit command words over a valid/ready input. Each word carries two things: a delay, in ticks, that must pass before anything happens on the bus, and one nibble. When the delay has run out, the block drives the nibble onto the four data lines and holds the enable strobe high for one tick. The register-select and read/write lines stay low the whole time. A plain list of words therefore describes a complete power-up timing script.

A free-running divider makes the tick from the system clock. The divide ratio is a parameter, and a ratio of 125 at 125 MHz gives roughly one microsecond per tick. A typical script sends nibble 0x3 three times with falling delays of 50000, 5000 and 200 ticks. It then sends nibble 0x2 after 200 ticks, nibble 0x2 again after 50, and finally nibble 0xC with no extra delay. After each strobe the block offers to take the next word. If no word is waiting, it emits a single-cycle completion pulse and goes back to idle.

Top module: `lcd_init_seq`

## Requirements
- R1: During and right after synchronous reset, the outputs are: strobe low, data lines 0, completion pulse low, ready high.
- R2: The data lines show bits 7..4 of the last accepted word from the cycle after acceptance onward. Bits 3..0 of the word have no effect on any output.
- R3: The strobe stays high for exactly TICK_DIV clock cycles. The data lines do not change while it is high.
- R4: Bits 31..8 of a word hold a count N. When a word is accepted in the cycle right after the previous strobe falls, the rise of its strobe comes TICK_DIV*(N+2) cycles after the previous strobe's rise. This includes N = 0.
- R5: Ready is high only while idle and in the single cycle after a strobe falls. Ready is never high while the strobe is high. A word is taken only when valid and ready are both high.
- R6: When the strobe falls and no word is valid in the next cycle, the completion pulse is high for exactly that one cycle. The block is then idle.
- R7: The register-select and read/write outputs are always 0.
- R8: While idle with no valid word, the strobe and the completion pulse stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | A command word is offered |
| cmdWord | input | 32 | Command word: delay count [31:8], nibble [7:4], padding [3:0] |
| cmdReady | output | 1 | The block takes the offered word this cycle |
| lcdE | output | 1 | LCD enable strobe |
| lcdDb | output | 4 | LCD data lines DB4..DB7 |
| lcdRs | output | 1 | Register select, held low |
| lcdRw | output | 1 | Read/write, held low |
| seqDone | output | 1 | One-cycle pulse when the word stream runs dry |

## Verification
Some internal faults show up at once. A stuck or wrong controller state shows on the ready or strobe outputs in the same cycle. A nibble latched from the wrong field shows on the data lines one cycle after acceptance. Errors in the delay counter or the tick divider are not visible until the next strobe rise: the rise comes early or late by a whole number of ticks. So the bench compares every output against a behavioural model on every clock, and it also measures the distance from one strobe rise to the next and the width of each strobe. A wrong decision at the end of a word shows in the cycle after the strobe falls, as a missing or extra completion pulse.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STROBE,
    ST_CHECK
  } seq_state_t;

  typedef struct packed {
    logic load;
    logic dec;
  } dp_ctrl_t;
endpackage

// File: rtl/lcd_init_dp.sv
module lcd_init_dp
  import lcd_init_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int WAIT_W   = 24,
  parameter int NIB_W    = 4,
  parameter int TICK_DIV = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_ctrl_t          ctrl,
  input  logic [WORD_W-1:0] word,
  output logic              tick,
  output logic              waitZero,
  output logic [NIB_W-1:0]  nibble
);
  localparam int TICK_W  = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int WAIT_LSB = WORD_W - WAIT_W;
  localparam int NIB_LSB  = WAIT_LSB - NIB_W;

  logic [TICK_W-1:0] tickCnt;
  logic [WAIT_W-1:0] waitCnt;

  assign tick     = (tickCnt == TICK_W'(TICK_DIV - 1));
  assign waitZero = (waitCnt == '0);

  always_ff @(posedge clk) begin
    if (rst || tick) tickCnt <= '0;
    else             tickCnt <= tickCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waitCnt <= '0;
      nibble  <= '0;
    end else if (ctrl.load) begin
      waitCnt <= word[WORD_W-1:WAIT_LSB];
      nibble  <= word[WAIT_LSB-1:NIB_LSB];
    end else if (ctrl.dec) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end
endmodule

// File: rtl/lcd_init_ctl.sv
module lcd_init_ctl
  import lcd_init_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cmdValid,
  input  logic     tick,
  input  logic     waitZero,
  output dp_ctrl_t ctrl,
  output logic     cmdReady,
  output logic     strobe,
  output logic     done
);
  seq_state_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctrl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          ctrl.load = 1'b1;
          nextState = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (tick) begin
          if (waitZero) nextState = ST_STROBE;
          else          ctrl.dec  = 1'b1;
        end
      end
      ST_STROBE: begin
        if (tick) nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (cmdValid) begin
          ctrl.load = 1'b1;
          nextState = ST_WAIT;
        end else begin
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign cmdReady = (state == ST_IDLE) || (state == ST_CHECK);
  assign strobe   = (state == ST_STROBE);
  assign done     = (state == ST_CHECK) && !cmdValid;
endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int WAIT_W   = 24,
  parameter int NIB_W    = 4,
  parameter int TICK_DIV = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  output logic              cmdReady,
  output logic              lcdE,
  output logic [NIB_W-1:0]  lcdDb,
  output logic              lcdRs,
  output logic              lcdRw,
  output logic              seqDone
);
  dp_ctrl_t ctrl;
  logic     tick;
  logic     waitZero;

  lcd_init_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .cmdValid (cmdValid),
    .tick     (tick),
    .waitZero (waitZero),
    .ctrl     (ctrl),
    .cmdReady (cmdReady),
    .strobe   (lcdE),
    .done     (seqDone)
  );

  lcd_init_dp #(
    .WORD_W   (WORD_W),
    .WAIT_W   (WAIT_W),
    .NIB_W    (NIB_W),
    .TICK_DIV (TICK_DIV)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .word     (cmdWord),
    .tick     (tick),
    .waitZero (waitZero),
    .nibble   (lcdDb)
  );

  assign lcdRs = 1'b0;
  assign lcdRw = 1'b0;
endmodule

// File: rtl/lcd_init_chk.sv
module lcd_init_chk #(
  parameter int NIB_W    = 4,
  parameter int TICK_DIV = 125
) (
  input logic             clk,
  input logic             rst,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic             lcdE,
  input logic [NIB_W-1:0] lcdDb,
  input logic             lcdRs,
  input logic             lcdRw,
  input logic             seqDone
);
  localparam int CNT_W = $clog2(TICK_DIV + 2);
  logic [CNT_W-1:0] eHighCnt;

  always_ff @(posedge clk) begin
    if (rst || !lcdE) eHighCnt <= '0;
    else              eHighCnt <= eHighCnt + 1'b1;
  end

  p_e_width_r3: assert property (@(posedge clk) disable iff (rst)
    lcdE |-> (eHighCnt < CNT_W'(TICK_DIV)));

  p_e_min_width_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(lcdE) |-> ($past(eHighCnt) == CNT_W'(TICK_DIV - 1)));

  p_db_stable_r3: assert property (@(posedge clk) disable iff (rst)
    lcdE |=> (!lcdE || $stable(lcdDb)));

  p_busy_not_ready_r5: assert property (@(posedge clk) disable iff (rst)
    lcdE |-> !cmdReady);

  p_ready_after_e_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(lcdE) |-> cmdReady);

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    seqDone |=> !seqDone);

  p_done_cause_r6: assert property (@(posedge clk) disable iff (rst)
    seqDone |-> (!cmdValid && cmdReady && $fell(lcdE)));

  p_rsrw_low_r7: assert property (@(posedge clk) disable iff (rst)
    !lcdRs && !lcdRw);
endmodule

bind lcd_init_seq lcd_init_chk #(
  .NIB_W    (NIB_W),
  .TICK_DIV (TICK_DIV)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .lcdE     (lcdE),
  .lcdDb    (lcdDb),
  .lcdRs    (lcdRs),
  .lcdRw    (lcdRw),
  .seqDone  (seqDone)
);

// File: tb/lcd_init_seq_tb.sv
module lcd_init_seq_tb;
  localparam int DIV = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic [31:0] cmdWord = '0;
  logic        cmdReady, lcdE, lcdRs, lcdRw, seqDone;
  logic [3:0]  lcdDb;

  int checks = 0;
  int errors = 0;
  logic [31:0] wordQ[$];

  // behavioural model: 0 idle, 1 waiting, 2 strobe, 3 post-strobe
  int mPhase = 0, mTick = 0, mLeft = 0;
  logic [3:0] mNib = 4'h0;
  int cycle = 0, lastRise = -1, riseGap = -1, eWidth = 0;
  logic prevE = 1'b0;
  bit finished = 0;

  always #10 clk = ~clk;

  lcd_init_seq #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .cmdReady(cmdReady), .lcdE(lcdE), .lcdDb(lcdDb),
    .lcdRs(lcdRs), .lcdRw(lcdRw), .seqDone(seqDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  // model advance on the edge
  always @(posedge clk) begin
    cycle++;
    if (rst) begin
      mPhase = 0; mTick = 0; mLeft = 0; mNib = 4'h0;
    end else begin
      bit tk;
      tk = (mTick == DIV - 1);
      case (mPhase)
        0, 3: begin
          if (cmdValid) begin
            riseGap = (mPhase == 3) ? DIV * (int'(cmdWord[31:8]) + 2) : -1;
            mLeft = int'(cmdWord[31:8]);
            mNib  = cmdWord[7:4];
            mPhase = 1;
            void'(wordQ.pop_front());
          end else begin
            mPhase = 0;
          end
        end
        1: if (tk) begin
             if (mLeft == 0) mPhase = 2;
             else mLeft--;
           end
        2: if (tk) mPhase = 3;
        default: mPhase = 0;
      endcase
      mTick = tk ? 0 : mTick + 1;
    end
  end

  // compare and drive away from the edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit expRdy, expE, expDone;
      expRdy  = (mPhase == 0) || (mPhase == 3);
      expE    = (mPhase == 2);
      expDone = (mPhase == 3) && !cmdValid;
      chk(lcdE == expE, "R3 strobe", lcdE, expE);
      chk(lcdDb == mNib, "R2 data lines", lcdDb, mNib);
      chk(cmdReady == expRdy, "R5 ready", cmdReady, expRdy);
      chk(seqDone == expDone, "R6 done", seqDone, expDone);
      chk(!lcdRs && !lcdRw, "R7 rs/rw", {lcdRs, lcdRw}, 0);
      if (mPhase == 0 && !cmdValid)
        chk(!lcdE && !seqDone, "R8 idle quiet", {lcdE, seqDone}, 0);
      if (lcdE && !prevE) begin
        if (lastRise >= 0 && riseGap >= 0)
          chk(cycle - lastRise == riseGap, "R4 rise spacing", cycle - lastRise, riseGap);
        lastRise = cycle;
        eWidth = 0;
      end
      if (lcdE) eWidth++;
      if (!lcdE && prevE)
        chk(eWidth == DIV, "R3 strobe width", eWidth, DIV);
      prevE = lcdE;
    end
    cmdValid <= (wordQ.size() > 0);
    cmdWord  <= (wordQ.size() > 0) ? wordQ[0] : 32'h0;
  end

  function automatic logic [31:0] mk(input int w, input logic [3:0] n, input logic [3:0] pad);
    return {w[23:0], n, pad};
  endfunction

  task automatic waitDone();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (seqDone) return;
    end
    chk(0, "R6 done never seen", 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(lcdE == 0 && lcdDb == 0 && seqDone == 0 && cmdReady == 1,
        "R1 reset outputs", {lcdE, lcdDb, seqDone, cmdReady}, 1);
    @(negedge clk);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    // scaled power-up script
    wordQ.push_back(mk(50, 4'h3, 4'h0));
    wordQ.push_back(mk(5, 4'h3, 4'h0));
    wordQ.push_back(mk(2, 4'h3, 4'h0));
    wordQ.push_back(mk(2, 4'h2, 4'h0));
    wordQ.push_back(mk(1, 4'h2, 4'h0));
    wordQ.push_back(mk(0, 4'hC, 4'h0));
    waitDone();
    repeat (17) @(negedge clk);
    // padding bits set: must behave as if clear (R2)
    wordQ.push_back(mk(3, 4'hA, 4'hF));
    wordQ.push_back(mk(0, 4'h5, 4'h9));
    wordQ.push_back(mk(0, 4'hF, 4'h6));
    waitDone();
    repeat (9) @(negedge clk);
    // lone word with zero delay
    wordQ.push_back(mk(0, 4'h1, 4'h3));
    waitDone();
    repeat (10) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule